// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address, tagged with a 7-bit address-space identifier, into a physical address by reading a two-level translation table out of memory. A small configuration port holds a global translation enable and a table of directory base frames, one per identifier. To load that table, software writes an identifier to a select register and then writes the base frame and its permission bits to a data register.

With translation enabled, an accepted request first checks the base permissions. It then reads the directory entry, which must carry the next-level flag and the needed permission, and then the table entry. The block answers with the physical address, or with a fault at the first level that fails. With translation disabled, the virtual address comes back unchanged one cycle after acceptance, and no memory read is made. The block handles one walk at a time, and the memory port has at most one read outstanding.

Top module: `two_level_walker`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o and mem_req_o are 0, translation is disabled, and every identifier's base has neither read nor write permission, so an enabled request to an identifier that was never programmed faults without a memory read.
- R2: While translation is disabled, an accepted request gets rsp_valid_o in the next cycle with rsp_pa_o equal to the request address and rsp_fault_o 0, and no memory read is made.
- R3: On a configuration write, cfg_addr_i 0 sets the enable from cfg_wdata_i[0]. Address 1 selects the identifier from cfg_wdata_i[6:0]. Address 2 stores, for the selected identifier, base frame cfg_wdata_i[19:0], readable bit 31 and writable bit 30. Address 3 has no effect.
- R4: The directory read address is {base_frame, va[31:22], 2'b00}. The table read address is {dir_entry[19:0], va[21:12], 2'b00}.
- R5: A directory entry with bit 28 clear ends the walk with a fault after that single read.
- R6: A read request needs bit 31 and a write request needs bit 30. This is checked at the base, the directory entry and the table entry. The walk faults at the first level that lacks the permission and makes no further read.
- R7: A walk that succeeds returns rsp_fault_o 0 and rsp_pa_o = {table_entry[19:0], va[11:0]}.
- R8: A fault response has rsp_pa_o equal to 0.
- R9: mem_req_o stays high with a stable mem_addr_o until the cycle in which mem_rvalid_i is seen, and only one read is outstanding.
- R10: req_ready_o is 1 only when no walk is in progress. Request inputs that change or stay asserted during a walk do not affect its result.
- R11: rsp_valid_o is a one-cycle pulse that arrives 1 + N*(W+1) cycles after acceptance, where N is the number of memory reads and W is the number of wait cycles before each mem_rvalid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register: 0 enable, 1 identifier select, 2 base data |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle; request accepted when valid |
| req_asid_i | input | 7 | Address-space identifier of the request |
| req_va_i | input | 32 | Virtual address |
| req_write_i | input | 1 | 1 for write access, 0 for read |
| mem_req_o | output | 1 | Memory read request, held until response |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| rsp_valid_o | output | 1 | Translation result valid (one cycle) |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_pa_o | output | 32 | Physical address (0 on fault) |

## Verification
Each result is due in a cycle that follows from the requirements. A bypass answer or a base-permission fault comes one cycle after acceptance. Each memory read adds its wait cycles plus one. The reference model in the bench works out, for every request, the number of reads and the addresses it expects. From these it derives the exact cycle of the response. The bench then compares rsp_valid_o, req_ready_o and the memory request against those expectations at every falling edge of the walk, so a response that comes early, comes late or repeats is reported in the cycle where it differs.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W     = 32;
  localparam int FRAME_W  = 20;
  localparam int IDX_W    = 10;
  localparam int OFF_W    = 12;
  localparam int BIT_RD   = 31;
  localparam int BIT_WR   = 30;
  localparam int BIT_NEXT = 28;

  typedef enum logic [1:0] {
    CFG_ENABLE   = 2'd0,
    CFG_ASID_SEL = 2'd1,
    CFG_BASE     = 2'd2,
    CFG_NONE     = 2'd3
  } cfg_addr_e;

  typedef struct packed {
    logic               rd;
    logic               wr;
    logic [FRAME_W-1:0] frame;
  } base_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_RSP  = 2'd3
  } state_e;
endpackage

// File: rtl/ptw_cfg_regs.sv
module ptw_cfg_regs
  import ptw_pkg::*;
#(
  parameter int ASID_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [ASID_W-1:0] rd_asid_i,
  output logic              en_o,
  output base_t             rd_base_o
);
  localparam int NUM_ASID = 1 << ASID_W;

  logic              en_q;
  logic [ASID_W-1:0] sel_q;
  base_t             tbl_q [NUM_ASID];
  logic              base_we;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata_i[29:FRAME_W];
  assign base_we = cfg_we_i && (cfg_addr_e'(cfg_addr_i) == CFG_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (cfg_we_i) begin
      case (cfg_addr_e'(cfg_addr_i))
        CFG_ENABLE:   en_q  <= cfg_wdata_i[0];
        CFG_ASID_SEL: sel_q <= cfg_wdata_i[ASID_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_ASID; g++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tbl_q[g] <= '0;
      end else if (base_we && (sel_q == ASID_W'(g))) begin
        tbl_q[g] <= '{rd: cfg_wdata_i[BIT_RD], wr: cfg_wdata_i[BIT_WR],
                      frame: cfg_wdata_i[FRAME_W-1:0]};
      end
    end
  end

  assign en_o      = en_q;
  assign rd_base_o = tbl_q[rd_asid_i];
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check #(
  parameter bit NEEDS_NEXT = 1'b0
) (
  input  logic rd_i,
  input  logic wr_i,
  input  logic next_i,
  input  logic need_wr_i,
  output logic ok_o
);
  logic perm_ok;
  assign perm_ok = need_wr_i ? wr_i : rd_i;

  if (NEEDS_NEXT) begin : g_dir
    assign ok_o = perm_ok && next_i;
  end else begin : g_leaf
    logic unused_next;
    assign unused_next = next_i;
    assign ok_o = perm_ok;
  end
endmodule

// File: rtl/two_level_walker.sv
module two_level_walker
  import ptw_pkg::*;
#(
  parameter int ASID_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ASID_W-1:0] req_asid_i,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic              req_write_i,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [VA_W-1:0]   rsp_pa_o
);
  localparam int TBL_LSB = OFF_W;
  localparam int DIR_LSB = OFF_W + IDX_W;

  state_e             state_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [FRAME_W-1:0] frame_q;
  logic               fault_q;
  logic [VA_W-1:0]    pa_q;
  logic               en_q;
  base_t              base;
  logic               base_ok, dir_ok, tbl_ok, accept;
  logic [IDX_W-1:0]   idx;
  logic               unused_rdata;

  assign unused_rdata = ^{mem_rdata_i[29], mem_rdata_i[27:FRAME_W]};

  ptw_cfg_regs #(.ASID_W(ASID_W)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .rd_asid_i(req_asid_i), .en_o(en_q), .rd_base_o(base)
  );

  ptw_entry_check #(.NEEDS_NEXT(1'b0)) u_chk_base (
    .rd_i(base.rd), .wr_i(base.wr), .next_i(1'b0),
    .need_wr_i(req_write_i), .ok_o(base_ok)
  );
  ptw_entry_check #(.NEEDS_NEXT(1'b1)) u_chk_dir (
    .rd_i(mem_rdata_i[BIT_RD]), .wr_i(mem_rdata_i[BIT_WR]),
    .next_i(mem_rdata_i[BIT_NEXT]), .need_wr_i(wr_q), .ok_o(dir_ok)
  );
  ptw_entry_check #(.NEEDS_NEXT(1'b0)) u_chk_tbl (
    .rd_i(mem_rdata_i[BIT_RD]), .wr_i(mem_rdata_i[BIT_WR]),
    .next_i(mem_rdata_i[BIT_NEXT]), .need_wr_i(wr_q), .ok_o(tbl_ok)
  );

  assign accept = req_valid_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      frame_q <= '0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          va_q <= req_va_i;
          wr_q <= req_write_i;
          if (!en_q) begin
            fault_q <= 1'b0;
            pa_q    <= req_va_i;
            state_q <= ST_RSP;
          end else if (!base_ok) begin
            fault_q <= 1'b1;
            pa_q    <= '0;
            state_q <= ST_RSP;
          end else begin
            frame_q <= base.frame;
            state_q <= ST_DIR;
          end
        end
        ST_DIR: if (mem_rvalid_i) begin
          if (dir_ok) begin
            frame_q <= mem_rdata_i[FRAME_W-1:0];
            state_q <= ST_TBL;
          end else begin
            fault_q <= 1'b1;
            pa_q    <= '0;
            state_q <= ST_RSP;
          end
        end
        ST_TBL: if (mem_rvalid_i) begin
          fault_q <= !tbl_ok;
          pa_q    <= tbl_ok ? {mem_rdata_i[FRAME_W-1:0], va_q[OFF_W-1:0]} : '0;
          state_q <= ST_RSP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx         = (state_q == ST_DIR) ? va_q[DIR_LSB +: IDX_W] : va_q[TBL_LSB +: IDX_W];
  assign mem_addr_o  = {frame_q, idx, 2'b00};
  assign mem_req_o   = (state_q == ST_DIR) || (state_q == ST_TBL);
  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RSP);
  assign rsp_fault_o = fault_q;
  assign rsp_pa_o    = pa_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [31:0] req_va_i,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic        rsp_valid_o,
  input logic        rsp_fault_o,
  input logic [31:0] rsp_pa_o,
  input logic        en_q
);
  assert_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !en_q |=>
      rsp_valid_o && !rsp_fault_o && rsp_pa_o == $past(req_va_i));

  assert_fault_pa_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_pa_o == 32'd0);

  assert_mem_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !rsp_valid_o);

  assert_rsp_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

bind two_level_walker ptw_checker u_ptw_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .req_va_i(req_va_i), .mem_req_o(mem_req_o),
  .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
  .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o),
  .rsp_pa_o(rsp_pa_o), .en_q(en_q)
);

// File: tb/sim_two_level_walker.sv
`timescale 1ns/1ps
module sim_two_level_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_asid = '0;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_pa;

  always #2.5 clk = ~clk;

  two_level_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_asid_i(req_asid), .req_va_i(req_va), .req_write_i(req_write),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault),
    .rsp_pa_o(rsp_pa)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference state
  bit         m_en = 0;
  bit [6:0]   m_sel = 0;
  bit [19:0]  m_frame [128];
  bit         m_rd [128];
  bit         m_wr [128];
  bit [31:0]  mem [bit [31:0]];
  bit [31:0]  exp_addr_q [$];
  int         mem_lat = 0;

  localparam bit [31:0] RD = 32'h8000_0000, WR = 32'h4000_0000, NX = 32'h1000_0000;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] rd_mem(input bit [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  // memory responder with programmable wait cycles
  bit        busy = 0;
  int        cnt = 0;
  bit [31:0] cur_addr = 0;
  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      busy = 0;
    end
    if (!busy && mem_req) begin
      busy = 1;
      cnt = mem_lat;
      cur_addr = mem_addr;
      if (exp_addr_q.size() == 0) chk(0, "R6 unexpected read", mem_addr, 0);
      else begin
        bit [31:0] e;
        e = exp_addr_q.pop_front();
        chk(mem_addr == e, "R4 read address", mem_addr, e);
      end
    end else if (busy) begin
      chk(mem_req && mem_addr == cur_addr, "R9 request held", mem_addr, cur_addr);
    end
    if (busy) begin
      if (cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = rd_mem(cur_addr);
      end else cnt--;
    end
  end

  task automatic model(input int asid, input bit [31:0] va, input bit wr,
                       output bit f, output bit [31:0] pa, output int reads);
    bit [31:0] a, pde, pte;
    exp_addr_q.delete();
    reads = 0; f = 1; pa = 0;
    if (!m_en) begin f = 0; pa = va; return; end
    if (!(wr ? m_wr[asid] : m_rd[asid])) return;
    a = {m_frame[asid], va[31:22], 2'b00};
    exp_addr_q.push_back(a); reads = 1;
    pde = rd_mem(a);
    if (!pde[28] || !(wr ? pde[30] : pde[31])) return;
    a = {pde[19:0], va[21:12], 2'b00};
    exp_addr_q.push_back(a); reads = 2;
    pte = rd_mem(a);
    if (!(wr ? pte[30] : pte[31])) return;
    f = 0; pa = {pte[19:0], va[11:0]};
  endtask

  task automatic cfg_write(input bit [1:0] a, input bit [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (a)
      2'd0: m_en = d[0];
      2'd1: m_sel = d[6:0];
      2'd2: begin m_frame[m_sel] = d[19:0]; m_rd[m_sel] = d[31]; m_wr[m_sel] = d[30]; end
      default: ;
    endcase
  endtask

  task automatic set_dir(input int asid, input bit [31:0] va, input bit [31:0] v);
    mem[{m_frame[asid], va[31:22], 2'b00}] = v;
  endtask
  task automatic set_tbl(input bit [19:0] tf, input bit [31:0] va, input bit [31:0] v);
    mem[{tf, va[21:12], 2'b00}] = v;
  endtask

  task automatic walk(input int asid, input bit [31:0] va, input bit wr,
                      input string tag, input bit disturb);
    bit f; bit [31:0] pa; int reads, d;
    model(asid, va, wr, f, pa, reads);
    d = 1 + reads * (mem_lat + 1);
    @(negedge clk);
    chk(req_ready == 1, "R10 ready when idle", req_ready, 1);
    req_valid = 1; req_asid = 7'(asid); req_va = va; req_write = wr;
    for (int n = 1; n <= d; n++) begin
      @(negedge clk);
      if (n == 1 && disturb) begin
        req_va = ~va; req_asid = 7'(asid ^ 1); req_write = ~wr;
      end else if (n == 1) req_valid = 0;
      chk(req_ready == 0, "R10 busy", req_ready, 0);
      chk(rsp_valid == (n == d), "R11 response timing", rsp_valid, n == d);
      if (n == d) begin
        req_valid = 0;
        chk(rsp_fault == f, {tag, " fault"}, rsp_fault, f);
        chk(rsp_pa == pa, {tag, f ? " R8 pa" : " pa"}, rsp_pa, pa);
      end
    end
    @(negedge clk);
    chk(rsp_valid == 0, "R11 single pulse", rsp_valid, 0);
    chk(exp_addr_q.size() == 0, "R4 all reads made", exp_addr_q.size(), 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin m_frame[i] = 0; m_rd[i] = 0; m_wr[i] = 0; end
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    chk(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    chk(mem_req == 0, "R1 mem_req", mem_req, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: disabled, pass-through
    walk(3, 32'hDEAD_B123, 0, "R2 bypass read", 0);
    walk(5, 32'h0040_5ABC, 1, "R2 bypass write", 0);

    // R1: enabled, unprogrammed base faults without reads
    cfg_write(2'd0, 32'd1);
    walk(3, 32'h0040_5ABC, 0, "R1 empty base", 0);

    // R3: program two identifiers
    cfg_write(2'd1, 32'd3);
    cfg_write(2'd2, RD | WR | 32'h00100);
    cfg_write(2'd1, 32'd9);
    cfg_write(2'd2, RD | 32'h00200);
    cfg_write(2'd3, 32'h0000_0000);    // R3: no effect

    set_dir(3, 32'h0040_5ABC, RD | WR | NX | 32'h00300);
    set_tbl(20'h00300, 32'h0040_5ABC, RD | WR | 32'h12345);
    set_tbl(20'h00300, 32'h0040_7000, RD | 32'h0ABCD);
    set_dir(3, 32'h0080_0000, RD | WR | 32'h00400);      // next flag clear
    set_dir(9, 32'h0000_1000, WR | NX | 32'h00500);      // not readable
    set_dir(9, 32'h0400_2000, RD | NX | 32'h00600);
    set_tbl(20'h00600, 32'h0400_2000, RD | 32'hFFFFF);

    walk(3, 32'h0040_5ABC, 0, "R7 translate read", 0);
    mem_lat = 2;
    walk(3, 32'h0040_5ABC, 1, "R9 translate write waited", 0);
    mem_lat = 0;
    walk(3, 32'h0040_7123, 0, "R7 leaf read ok", 0);
    walk(3, 32'h0040_7123, 1, "R6 leaf lacks write", 0);
    walk(3, 32'h0080_0FFF, 0, "R5 no next level", 0);
    walk(9, 32'h0000_1000, 1, "R6 base lacks write", 0);
    walk(9, 32'h0000_1000, 0, "R6 dir lacks read", 0);
    walk(9, 32'h0400_2FFF, 0, "R7 max frame", 0);
    walk(3, 32'h1234_5678, 0, "R5 unmapped directory", 0);
    mem_lat = 1;
    walk(3, 32'h0040_5ABC, 0, "R10 inputs changed mid-walk", 1);
    mem_lat = 0;

    // R3: rewrite base of 3 only; 9 untouched
    cfg_write(2'd1, 32'd3);
    cfg_write(2'd2, WR | 32'h00100);
    walk(3, 32'h0040_5ABC, 0, "R3 base rewritten", 0);
    walk(9, 32'h0400_2FFF, 0, "R3 other base kept", 0);

    cfg_write(2'd0, 32'd0);
    walk(9, 32'h0400_2FFF, 1, "R2 disabled again", 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule